// File: doc/BRIEF.md
# Strided Store Descriptor Validator

This block screens a 64-byte store-instruction descriptor before it is dispatched. The descriptor is presented as a single 512-bit word together with a one-cycle strobe. One clock later the block returns a verdict: a pulse marking the verdict, a legal flag, and a 4-bit reason code. The code names the first rule the descriptor breaks.

The rules cover several fields: the opcode byte, the two element counts and their product, the element type, and the data-source selector. They also cover the per-type cap on immediate element counts, even register numbering when 64-bit values come from registers, and natural alignment of a start address given in immediate form. Bytes are little-endian within the descriptor: byte k occupies bits 8k+7..8k. Header bytes beyond the opcode and the event bytes are not examined.

A small two-state controller decides when the verdict is presented. State IDLE moves to REPORT on a strobe. REPORT stays in REPORT on a further strobe and returns to IDLE without one. The verdict outputs are valid only in REPORT.

Top module: `store_desc_checker`

## Requirements
- R1: A strobe on `desc_valid` at a rising edge makes `verdict_valid` high for the following cycle. With no strobe, `verdict_valid` is low in the following cycle. Back-to-back strobes give back-to-back verdicts.
- R2: Byte 0 must equal 0xAB. Any other value, including the load opcode 0xAA, gives reason code 1.
- R3: Byte 14 and byte 15 are the two element counts. Each must lie in 1..32 and their product must not exceed 32; otherwise the reason code is 2.
- R4: Byte 12 is the type code. The accepted codes are 0x1 (u64, 8 bytes), 0x2 (i8), 0x3 (u8), 0x4 (i16), 0x5 (u16), 0x8 (i32), 0x9 (u32) and 0xA (fp32, 4 bytes). Any other code, 0xB included, gives reason code 3.
- R5: Byte 13 selects the source: 0 for register, 1 for immediate. Any other value gives reason code 4.
- R6: With an immediate source, the count product may not exceed 32 divided by the element size: 32 for 8-bit types, 16 for 16-bit types, 8 for 32-bit types, and 4 for u64. A register source allows 32. A breach gives reason code 5.
- R7: With type u64 and a register source, every one of the 32 payload bytes (bytes 32..63) must be even, used slot or not. Otherwise the reason code is 6. Other type and source combinations ignore payload parity.
- R8: Bytes 16..23 hold the start address; byte 23 gives its form. Form 0 means immediate, and then the address must be a multiple of the element size, or the reason code is 7. A nonzero form (register or table) skips the alignment check.
- R9: When several rules fail, the reason code is the first failure in this order: opcode, counts, type, source, count limit, register parity, alignment.
- R10: A descriptor that passes every rule gives `verdict_ok` = 1 and reason code 0. Any failure gives `verdict_ok` = 0.
- R11: While reset is asserted and after it is released, `verdict_valid` and `verdict_ok` are 0 and `verdict_code` is 0 until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Strobe: `desc` holds a descriptor this cycle |
| desc | input | 512 | Whole descriptor, byte k at bits 8k+7..8k |
| verdict_valid | output | 1 | Verdict presented this cycle |
| verdict_ok | output | 1 | Descriptor is legal |
| verdict_code | output | 4 | First failing rule, 0 when legal |

## Verification
Every result is due exactly one rising edge after the strobe that carried the descriptor. The verdict pulse, the legal flag and the reason code all appear in that same cycle. The bench changes inputs on falling edges and reads outputs on the next falling edge, so exactly one rising edge lies between stimulus and sample. For back-to-back strobes, each descriptor's verdict is read on the falling edge where the next descriptor is driven. An idle falling edge after a verdict confirms that the pulse lasts one cycle.

// File: rtl/sdv_pkg.sv
package sdv_pkg;

    localparam int unsigned DESC_BYTES = 64;
    localparam int unsigned DESC_W     = DESC_BYTES * 8;

    // Byte offsets the rules depend on
    localparam int unsigned OFF_OPCODE = 0;
    localparam int unsigned OFF_TYPE   = 12;
    localparam int unsigned OFF_SRC    = 13;
    localparam int unsigned OFF_CNT_IN = 14;
    localparam int unsigned OFF_CNT_OT = 15;
    localparam int unsigned OFF_ADDR   = 16;
    localparam int unsigned ADDR_BYTES = 8;
    localparam int unsigned OFF_PAY    = 32;

    typedef enum logic [3:0] {
        RC_LEGAL   = 4'd0,
        RC_OPCODE  = 4'd1,
        RC_COUNT   = 4'd2,
        RC_TYPE    = 4'd3,
        RC_SOURCE  = 4'd4,
        RC_LIMIT   = 4'd5,
        RC_REGPAIR = 4'd6,
        RC_ALIGN   = 4'd7
    } reason_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } vstate_e;

    localparam logic [7:0] TY_U64  = 8'h01;
    localparam logic [7:0] TY_I8   = 8'h02;
    localparam logic [7:0] TY_U8   = 8'h03;
    localparam logic [7:0] TY_I16  = 8'h04;
    localparam logic [7:0] TY_U16  = 8'h05;
    localparam logic [7:0] TY_I32  = 8'h08;
    localparam logic [7:0] TY_U32  = 8'h09;
    localparam logic [7:0] TY_F32  = 8'h0A;

    localparam logic [7:0] SRC_REG = 8'h00;
    localparam logic [7:0] SRC_IMM = 8'h01;

    function automatic logic type_known(input logic [7:0] t);
        case (t)
            TY_U64, TY_I8, TY_U8, TY_I16, TY_U16,
            TY_I32, TY_U32, TY_F32: type_known = 1'b1;
            default:                type_known = 1'b0;
        endcase
    endfunction

    // log2 of element size in bytes
    function automatic logic [1:0] type_shift(input logic [7:0] t);
        case (t)
            TY_U64:                 type_shift = 2'd3;
            TY_I32, TY_U32, TY_F32: type_shift = 2'd2;
            TY_I16, TY_U16:         type_shift = 2'd1;
            default:                type_shift = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/sdv_count_check.sv
module sdv_count_check #(
    parameter int unsigned MAX_ELEMS     = 32,
    parameter int unsigned PAYLOAD_BYTES = 32,
    parameter int unsigned CW            = 8
) (
    input  logic [CW-1:0] cnt_inner,
    input  logic [CW-1:0] cnt_outer,
    input  logic          src_is_imm,
    input  logic [1:0]    elem_shift,
    output logic          counts_bad,
    output logic          limit_bad
);
    localparam int unsigned PW = 2 * CW;
    localparam logic [PW-1:0] MAX_P = PW'(MAX_ELEMS);
    localparam logic [PW-1:0] PAY_P = PW'(PAYLOAD_BYTES);

    logic [PW-1:0] product;
    logic [PW-1:0] imm_cap;
    logic [PW-1:0] cap;

    always_comb begin
        product = PW'(cnt_inner) * PW'(cnt_outer);
        imm_cap = PAY_P >> elem_shift;
        cap     = src_is_imm ? imm_cap : MAX_P;

        counts_bad = (cnt_inner == '0) || (PW'(cnt_inner) > MAX_P) ||
                     (cnt_outer == '0) || (PW'(cnt_outer) > MAX_P) ||
                     (product > MAX_P);
        limit_bad  = product > cap;
    end

endmodule

// File: rtl/sdv_reg_parity.sv
module sdv_reg_parity #(
    parameter int unsigned SLOTS = 32
) (
    input  logic [SLOTS*8-1:0] payload,
    output logic               any_odd
);
    logic [SLOTS-1:0] odd_bits;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign odd_bits[g] = payload[g*8];
    end

    assign any_odd = |odd_bits;

endmodule

// File: rtl/sdv_align_check.sv
module sdv_align_check (
    input  logic [7:0] addr_form,
    input  logic [2:0] addr_low,
    input  logic [1:0] elem_shift,
    output logic       misaligned
);
    logic [2:0] mask;

    always_comb begin
        mask       = 3'((4'd1 << elem_shift) - 4'd1);
        misaligned = (addr_form == 8'h00) && ((addr_low & mask) != 3'd0);
    end

endmodule

// File: rtl/store_desc_checker.sv
module store_desc_checker
    import sdv_pkg::*;
#(
    parameter int unsigned MAX_ELEMS     = 32,
    parameter int unsigned PAYLOAD_BYTES = 32,
    parameter logic [7:0]  STORE_OPCODE  = 8'hAB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    input  logic [DESC_W-1:0] desc,
    output logic              verdict_valid,
    output logic              verdict_ok,
    output logic [3:0]        verdict_code
);
    localparam int unsigned PAY_W   = PAYLOAD_BYTES * 8;
    localparam int unsigned ADDR_W  = ADDR_BYTES * 8;

    // Field extraction
    logic [7:0]        f_opcode, f_type, f_src, f_cnt_in, f_cnt_ot, f_form;
    logic [ADDR_W-1:0] f_addr;
    logic [PAY_W-1:0]  f_pay;

    assign f_opcode = desc[OFF_OPCODE*8 +: 8];
    assign f_type   = desc[OFF_TYPE*8   +: 8];
    assign f_src    = desc[OFF_SRC*8    +: 8];
    assign f_cnt_in = desc[OFF_CNT_IN*8 +: 8];
    assign f_cnt_ot = desc[OFF_CNT_OT*8 +: 8];
    assign f_addr   = desc[OFF_ADDR*8   +: ADDR_W];
    assign f_form   = f_addr[ADDR_W-1 -: 8];
    assign f_pay    = desc[OFF_PAY*8    +: PAY_W];

    logic [1:0] elem_shift;
    logic       src_is_imm;
    assign elem_shift = type_shift(f_type);
    assign src_is_imm = (f_src == SRC_IMM);

    logic counts_bad, limit_bad, any_odd, misaligned;

    sdv_count_check #(
        .MAX_ELEMS     (MAX_ELEMS),
        .PAYLOAD_BYTES (PAYLOAD_BYTES),
        .CW            (8)
    ) i_count (
        .cnt_inner  (f_cnt_in),
        .cnt_outer  (f_cnt_ot),
        .src_is_imm (src_is_imm),
        .elem_shift (elem_shift),
        .counts_bad (counts_bad),
        .limit_bad  (limit_bad)
    );

    sdv_reg_parity #(
        .SLOTS (PAYLOAD_BYTES)
    ) i_parity (
        .payload (f_pay),
        .any_odd (any_odd)
    );

    sdv_align_check i_align (
        .addr_form  (f_form),
        .addr_low   (f_addr[2:0]),
        .elem_shift (elem_shift),
        .misaligned (misaligned)
    );

    // Fixed-priority reason selection
    reason_e reason_d;

    always_comb begin
        if (f_opcode != STORE_OPCODE)
            reason_d = RC_OPCODE;
        else if (counts_bad)
            reason_d = RC_COUNT;
        else if (!type_known(f_type))
            reason_d = RC_TYPE;
        else if ((f_src != SRC_REG) && (f_src != SRC_IMM))
            reason_d = RC_SOURCE;
        else if (limit_bad)
            reason_d = RC_LIMIT;
        else if ((f_type == TY_U64) && (f_src == SRC_REG) && any_odd)
            reason_d = RC_REGPAIR;
        else if (misaligned)
            reason_d = RC_ALIGN;
        else
            reason_d = RC_LEGAL;
    end

    // Controller
    vstate_e state_q, state_d;
    reason_e reason_q;

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = desc_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = desc_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            reason_q <= RC_LEGAL;
        end else begin
            state_q <= state_d;
            if (desc_valid)
                reason_q <= reason_d;
        end
    end

    always_comb begin
        verdict_valid = 1'b0;
        verdict_ok    = 1'b0;
        verdict_code  = reason_q;
        unique case (state_q)
            ST_IDLE: begin
                verdict_valid = 1'b0;
                verdict_ok    = 1'b0;
            end
            ST_REPORT: begin
                verdict_valid = 1'b1;
                verdict_ok    = (reason_q == RC_LEGAL);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sdv_checker.sv
module sdv_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         desc_valid,
    input logic [511:0] desc,
    input logic         verdict_valid,
    input logic         verdict_ok,
    input logic [3:0]   verdict_code
);
    // R1: verdict exactly one cycle after a strobe
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |=> verdict_valid);

    // R1: no verdict without a strobe
    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !desc_valid |=> !verdict_valid);

    // R2: wrong opcode is reported first
    p_opcode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc[7:0] != 8'hAB) |=> (verdict_code == 4'd1 && !verdict_ok));

    // R3: a zero count is a count failure when the opcode is right
    p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc[7:0] == 8'hAB &&
         (desc[119:112] == 8'd0 || desc[127:120] == 8'd0)) |=> (verdict_code == 4'd2));

    // R4: code 0x0B is rejected when opcode and small counts are fine
    p_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc[7:0] == 8'hAB && desc[103:96] == 8'h0B &&
         desc[119:112] == 8'd1 && desc[127:120] == 8'd1) |=> (verdict_code == 4'd3));

    // R5: bad source with an otherwise clean u8 descriptor
    p_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc[7:0] == 8'hAB && desc[103:96] == 8'h03 &&
         desc[111:104] > 8'd1 &&
         desc[119:112] == 8'd1 && desc[127:120] == 8'd1) |=> (verdict_code == 4'd4));

endmodule

bind store_desc_checker sdv_checker i_sdv_checker (.*);

// File: tb/test_store_desc_checker.sv
module test_store_desc_checker;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] opc;
        logic [7:0] ty;
        logic [7:0] src;
        logic [7:0] n0;
        logic [7:0] n1;
        logic [7:0] form;
        logic [7:0] alo;
        logic [7:0] odd;   // payload slot made odd, FF = none
        logic [3:0] exp;
    } vec_t;

    localparam int NVEC = 37;
    localparam vec_t VECS [NVEC] = '{
        '{8'hAB,8'h09,8'h00,8'd4 ,8'd2 ,8'h00,8'h10,8'hFF,4'd0}, // R10 legal u32 reg
        '{8'hAA,8'h09,8'h00,8'd4 ,8'd2 ,8'h00,8'h10,8'hFF,4'd1}, // R2 load opcode
        '{8'h00,8'h09,8'h00,8'd4 ,8'd2 ,8'h00,8'h10,8'hFF,4'd1}, // R2
        '{8'hAB,8'h09,8'h00,8'd0 ,8'd2 ,8'h00,8'h10,8'hFF,4'd2}, // R3 zero count
        '{8'hAB,8'h09,8'h00,8'd33,8'd1 ,8'h00,8'h10,8'hFF,4'd2}, // R3 count 33
        '{8'hAB,8'h09,8'h00,8'd8 ,8'd5 ,8'h00,8'h10,8'hFF,4'd2}, // R3 product 40
        '{8'hAB,8'h09,8'h00,8'd1 ,8'd32,8'h00,8'h10,8'hFF,4'd0}, // R3 product 32
        '{8'hAB,8'h0B,8'h00,8'd4 ,8'd2 ,8'h00,8'h10,8'hFF,4'd3}, // R4 0x0B
        '{8'hAB,8'h00,8'h00,8'd4 ,8'd2 ,8'h00,8'h10,8'hFF,4'd3}, // R4 0x00
        '{8'hAB,8'h06,8'h00,8'd4 ,8'd2 ,8'h00,8'h10,8'hFF,4'd3}, // R4 0x06
        '{8'hAB,8'h09,8'h02,8'd4 ,8'd2 ,8'h00,8'h10,8'hFF,4'd4}, // R5 source 2
        '{8'hAB,8'h05,8'h01,8'd4 ,8'd4 ,8'h00,8'h10,8'hFF,4'd0}, // R6 imm u16 16
        '{8'hAB,8'h05,8'h01,8'd17,8'd1 ,8'h00,8'h10,8'hFF,4'd5}, // R6 imm u16 17
        '{8'hAB,8'h09,8'h01,8'd9 ,8'd1 ,8'h00,8'h10,8'hFF,4'd5}, // R6 imm u32 9
        '{8'hAB,8'h0A,8'h01,8'd8 ,8'd1 ,8'h00,8'h10,8'hFF,4'd0}, // R6 imm fp32 8
        '{8'hAB,8'h08,8'h01,8'd3 ,8'd3 ,8'h00,8'h10,8'hFF,4'd5}, // R6 imm i32 9
        '{8'hAB,8'h01,8'h01,8'd5 ,8'd1 ,8'h00,8'h10,8'hFF,4'd5}, // R6 imm u64 5
        '{8'hAB,8'h01,8'h01,8'd4 ,8'd1 ,8'h00,8'h08,8'hFF,4'd0}, // R6 imm u64 4
        '{8'hAB,8'h03,8'h01,8'd32,8'd1 ,8'h00,8'h10,8'hFF,4'd0}, // R6 imm u8 32
        '{8'hAB,8'h02,8'h01,8'd4 ,8'd8 ,8'h00,8'h10,8'hFF,4'd0}, // R6 imm i8 32
        '{8'hAB,8'h01,8'h00,8'd32,8'd1 ,8'h00,8'h00,8'hFF,4'd0}, // R6 reg u64 32
        '{8'hAB,8'h01,8'h00,8'd1 ,8'd1 ,8'h00,8'h00,8'd31,4'd6}, // R7 unused odd slot
        '{8'hAB,8'h01,8'h01,8'd1 ,8'd1 ,8'h00,8'h00,8'd3 ,4'd0}, // R7 imm ignores parity
        '{8'hAB,8'h09,8'h00,8'd4 ,8'd2 ,8'h00,8'h10,8'd5 ,4'd0}, // R7 u32 ignores parity
        '{8'hAB,8'h09,8'h00,8'd1 ,8'd1 ,8'h00,8'h02,8'hFF,4'd7}, // R8 u32 at 2
        '{8'hAB,8'h09,8'h00,8'd1 ,8'd1 ,8'h01,8'h02,8'hFF,4'd0}, // R8 register form
        '{8'hAB,8'h05,8'h00,8'd1 ,8'd1 ,8'h00,8'h01,8'hFF,4'd7}, // R8 u16 at 1
        '{8'hAB,8'h04,8'h00,8'd1 ,8'd1 ,8'h00,8'h02,8'hFF,4'd0}, // R8 i16 at 2
        '{8'hAB,8'h01,8'h00,8'd1 ,8'd1 ,8'h00,8'h04,8'hFF,4'd7}, // R8 u64 at 4
        '{8'hAB,8'h01,8'h00,8'd1 ,8'd1 ,8'h02,8'h04,8'hFF,4'd0}, // R8 table form
        '{8'hAB,8'h02,8'h00,8'd1 ,8'd1 ,8'h00,8'h03,8'hFF,4'd0}, // R8 i8 at 3
        '{8'hAA,8'h09,8'h00,8'd0 ,8'd2 ,8'h00,8'h10,8'hFF,4'd1}, // R9 opcode before counts
        '{8'hAB,8'h0B,8'h00,8'd0 ,8'd2 ,8'h00,8'h10,8'hFF,4'd2}, // R9 counts before type
        '{8'hAB,8'h0B,8'h02,8'd1 ,8'd1 ,8'h00,8'h10,8'hFF,4'd3}, // R9 type before source
        '{8'hAB,8'h09,8'h02,8'd1 ,8'd1 ,8'h00,8'h02,8'hFF,4'd4}, // R9 source before align
        '{8'hAB,8'h09,8'h01,8'd9 ,8'd1 ,8'h00,8'h02,8'hFF,4'd5}, // R9 limit before align
        '{8'hAB,8'h01,8'h00,8'd1 ,8'd1 ,8'h00,8'h04,8'd0 ,4'd6}  // R9 parity before align
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         desc_valid = 1'b0;
    logic [511:0] desc = '0;
    logic         verdict_valid;
    logic         verdict_ok;
    logic [3:0]   verdict_code;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    store_desc_checker i_store_desc_checker (
        .clk           (clk),
        .rst_n         (rst_n),
        .desc_valid    (desc_valid),
        .desc          (desc),
        .verdict_valid (verdict_valid),
        .verdict_ok    (verdict_ok),
        .verdict_code  (verdict_code)
    );

    function automatic logic [511:0] build(input vec_t v);
        logic [511:0] d;
        d = '0;
        d[7:0]     = v.opc;
        d[95:8]    = 88'h5A_C3_11_22_33_44_55_66_77_88_99;
        d[103:96]  = v.ty;
        d[111:104] = v.src;
        d[119:112] = v.n0;
        d[127:120] = v.n1;
        d[135:128] = v.alo;
        d[183:136] = 48'h0000_0012_3400;
        d[191:184] = v.form;
        d[255:192] = 64'hFFFF_FFFE_0000_0003;
        for (int k = 0; k < 32; k++)
            d[256 + 8*k +: 8] = (k == int'(v.odd)) ? 8'(2*k + 1) : 8'(2*k);
        return d;
    endfunction

    function automatic string req_of(input logic [3:0] code);
        case (code)
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_verdict(input string req, input logic [3:0] exp);
        chk("R1", "verdict_valid", int'(verdict_valid), 1);
        chk(req, "verdict_code", int'(verdict_code), int'(exp));
        chk(req, "verdict_ok", int'(verdict_ok), int'(exp == 4'd0));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++;
        n_fail++;
        $display("FAIL R1 watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R11: reset state, including while a strobe is offered
        desc       = build(VECS[1]);
        desc_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11", "valid in reset", int'(verdict_valid), 0);
        chk("R11", "ok in reset", int'(verdict_ok), 0);
        chk("R11", "code in reset", int'(verdict_code), 0);
        desc_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R11", "valid after reset", int'(verdict_valid), 0);
        chk("R11", "code after reset", int'(verdict_code), 0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            desc       = build(VECS[i]);
            desc_valid = 1'b1;
            @(negedge clk);
            desc_valid = 1'b0;
            check_verdict(req_of(VECS[i].exp), VECS[i].exp);
            @(negedge clk);
        end

        // R1: pulse lasts one cycle
        desc       = build(VECS[0]);
        desc_valid = 1'b1;
        @(negedge clk);
        desc_valid = 1'b0;
        check_verdict("R10", 4'd0);
        @(negedge clk);
        chk("R1", "valid idle", int'(verdict_valid), 0);
        chk("R1", "ok idle", int'(verdict_ok), 0);

        // R1: back-to-back strobes
        desc       = build(VECS[1]);
        desc_valid = 1'b1;
        @(negedge clk);
        check_verdict("R2", 4'd1);
        desc = build(VECS[6]);
        @(negedge clk);
        check_verdict("R3", 4'd0);
        desc = build(VECS[28]);
        @(negedge clk);
        desc_valid = 1'b0;
        check_verdict("R8", 4'd7);
        @(negedge clk);
        chk("R1", "valid after burst", int'(verdict_valid), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule